// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide SPI link to a serial NOR flash. It turns a single request into the full command sequence the flash needs to change its array. First it sends a one-byte write-enable command in a chip-select frame of its own. Chip select then goes high for a guard interval, and the block sends the operation frame. After a second guard interval it polls the status register, one two-byte frame per poll, until the write-in-progress bit reads clear. It then reports completion.

Three operations are offered:

- **Page program** sends an opcode, three address bytes and 1 to 256 data bytes. The data bytes come from a streaming source.
- **Sector erase** sends an opcode and three address bytes.
- **Bulk erase** sends an opcode alone.

A polling limit set by the caller bounds the wait. If the limit runs out, the block raises a sticky error flag and finishes anyway.

The control is one state machine with these states:

| State | Chip select | What it does |
|---|---|---|
| IDLE | high | Waits for a request |
| WREN | low | Sends the write-enable byte |
| GAP_EN | high | Guard interval after write enable |
| OPCODE | low | Sends the operation opcode |
| ADDR | low | Sends the address bytes |
| DATA | low | Sends the data bytes |
| GAP_OP | high | Guard interval after the operation frame |
| RDSR | low | Sends the status-read opcode |
| STATUS | low | Clocks in the status byte |
| GAP_POLL | high | Guard interval after each poll |
| FINISH | high | Pulses done for one cycle |

Its transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | WREN | A request is accepted |
| WREN | GAP_EN | Byte complete |
| GAP_EN | OPCODE | Guard ends |
| OPCODE | GAP_OP | Bulk erase |
| OPCODE | ADDR | Otherwise |
| ADDR | DATA | Last address byte, program |
| ADDR | GAP_OP | Last address byte, erase |
| DATA | GAP_OP | Last data byte |
| GAP_OP | RDSR | Guard ends |
| RDSR | STATUS | Byte complete |
| STATUS | GAP_POLL | Byte complete |
| GAP_POLL | FINISH | Bit clear, or limit reached |
| GAP_POLL | RDSR | Still busy and limit not reached |
| FINISH | IDLE | Always |

A byte shifter under the state machine runs SPI mode 0. The clock idles low. Bits go out MSB first and change only while the clock is low. The input is sampled on each rising clock edge.

Top module: `spi_nor_writer`

## Requirements
- R1: After reset, spi_cs_n is high, spi_sck is low, and busy, done, data_req, err_len and err_timeout are all low.
- R2: A program request produces two frames, separated by chip-select high for at least CS_GAP cycles. The first frame is the single byte 06h. The second frame is 02h, then addr[23:16], addr[15:8] and addr[7:0], then byte_cnt data bytes in the order they are taken. Exactly one data_req pulse occurs per data byte, and data_in is taken in the cycle of that pulse.
- R3: The link works in SPI mode 0:
  - spi_sck is low whenever spi_cs_n is high.
  - Every byte goes out MSB first.
  - spi_mosi does not change while spi_sck stays high.
  - spi_miso is sampled on the rising edge of spi_sck.
- R4: A program request with byte_cnt equal to 0, or greater than 256, is rejected. err_len pulses for one cycle. No chip-select frame follows, busy stays low and no done occurs.
- R5: A sector-erase request produces the frame 06h, then the frame D8h followed by the three address bytes, most significant byte first.
- R6: A bulk-erase request produces the frame 06h, then a frame holding the single byte C7h.
- R7: After the operation frame, the block repeats a two-byte frame made of 05h followed by a dummy byte 00h. It treats bit 0 of the received status byte as write-in-progress and ignores the other bits. It stops after the first poll that reads bit 0 as 0.
- R8: busy is high from the cycle after a request is accepted until done. done is a one-cycle pulse, and busy is low in that cycle.
- R9: If poll_limit status reads in a row all show bit 0 set, polling stops. done then pulses with err_timeout high. err_timeout holds until the next accepted request, which clears it.
- R10: When several requests arrive in the same cycle, program wins over sector erase, and sector erase wins over bulk erase. Requests that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_prog | input | 1 | Page-program request |
| start_se | input | 1 | Sector-erase request |
| start_be | input | 1 | Bulk-erase request |
| addr | input | 24 | Flash byte address, latched when a request is accepted |
| byte_cnt | input | 9 | Number of program data bytes, valid range 1 to 256 |
| poll_limit | input | 16 | Maximum number of status reads |
| data_in | input | 8 | Program data byte from the source |
| data_req | output | 1 | Pulse: data_in is taken in this cycle and the source advances |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_len | output | 1 | One-cycle pulse: program request rejected for its length |
| err_timeout | output | 1 | Sticky flag: polling limit reached |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Faults inside the state machine show up on the link within one frame:

- A wrong state or a wrong branch shows as a missing write-enable frame, a wrong opcode, a wrong address byte, or an extra or short frame. The bench catches each of these by recording the link and comparing it against the expected byte and frame stream, built arithmetically for each request.
- A miscounted data index shows as a wrong number of data bytes or data_req pulses.
- A fault in the poll counter or the status-bit capture changes how many status frames appear and whether err_timeout goes high at done. A sweep of busy-poll counts around the limit exposes both.

Faults in the shifter show within one byte, either as a rotated byte or as an edge-rule violation seen by the link monitors.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

    localparam logic [7:0] OPC_WR_EN   = 8'h06;
    localparam logic [7:0] OPC_PAGE_WR = 8'h02;
    localparam logic [7:0] OPC_RD_STAT = 8'h05;
    localparam logic [7:0] OPC_SEC_ER  = 8'hD8;
    localparam logic [7:0] OPC_CHIP_ER = 8'hC7;

    typedef enum logic [1:0] {
        JOB_PROG,
        JOB_SEC,
        JOB_CHIP
    } job_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_GAP_EN,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_GAP_OP,
        ST_RDSR,
        ST_STATUS,
        ST_GAP_POLL,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic             active;
    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            div_q     <= '0;
            bit_q     <= '0;
            sh_q      <= '0;
            rx_byte   <= '0;
            sck       <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                sck <= 1'b0;
                if (go) begin
                    active <= 1'b1;
                    sh_q   <= tx_byte;
                    bit_q  <= '0;
                    div_q  <= '0;
                end
            end else if (div_q == DIV_W'(DIV - 1)) begin
                div_q <= '0;
                if (!sck) begin
                    // rising edge: capture the input bit
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    // falling edge: move to the next output bit
                    sck <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign mosi = sh_q[7];

    // R3: output data holds while the clock is high
    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R3: a new byte is only launched while the shifter is idle
    p_go_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import spi_nor_pkg::*;
#(
    parameter int GAP        = 2,
    parameter int POLL_W     = 16,
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_W     = 24
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_prog,
    input  logic                              start_se,
    input  logic                              start_be,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [$clog2(PAGE_BYTES+1)-1:0]   byte_cnt,
    input  logic [POLL_W-1:0]                 poll_limit,
    input  logic [7:0]                        data_in,
    output logic                              data_req,
    output logic                              busy,
    output logic                              done,
    output logic                              err_len,
    output logic                              err_timeout,
    output logic                              cs_n,
    output logic                              sh_go,
    output logic [7:0]                        sh_tx,
    input  logic [7:0]                        sh_rx,
    input  logic                              sh_done
);
    localparam int CNT_W      = $clog2(PAGE_BYTES + 1);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int GAP_W      = (GAP > 1) ? $clog2(GAP) : 1;

    seq_state_e        state, nxt;
    job_e              job_q, job_pick;
    logic [ADDR_W-1:0] addr_q, addr_sh;
    logic [CNT_W-1:0]  cnt_q, idx;
    logic [POLL_W-1:0] lim_q, polls;
    logic [GAP_W-1:0]  gcnt;
    logic              launched, wip;
    logic              len_ok, accept, in_gap, gap_end, poll_hit, byte_st;

    assign len_ok   = (byte_cnt != '0) && (byte_cnt <= CNT_W'(PAGE_BYTES));
    assign accept   = (state == ST_IDLE) &&
                      (start_prog ? len_ok : (start_se || start_be));
    assign job_pick = start_prog ? JOB_PROG : (start_se ? JOB_SEC : JOB_CHIP);
    assign in_gap   = (state == ST_GAP_EN) || (state == ST_GAP_OP) ||
                      (state == ST_GAP_POLL);
    assign gap_end  = in_gap && (gcnt == GAP_W'(GAP - 1));
    assign poll_hit = (polls >= lim_q);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (accept) nxt = ST_WREN;
            ST_WREN:     if (sh_done) nxt = ST_GAP_EN;
            ST_GAP_EN:   if (gap_end) nxt = ST_OPCODE;
            ST_OPCODE:   if (sh_done) nxt = (job_q == JOB_CHIP) ? ST_GAP_OP : ST_ADDR;
            ST_ADDR:     if (sh_done && idx == CNT_W'(ADDR_BYTES - 1))
                             nxt = (job_q == JOB_PROG) ? ST_DATA : ST_GAP_OP;
            ST_DATA:     if (sh_done && idx == cnt_q - CNT_W'(1)) nxt = ST_GAP_OP;
            ST_GAP_OP:   if (gap_end) nxt = ST_RDSR;
            ST_RDSR:     if (sh_done) nxt = ST_STATUS;
            ST_STATUS:   if (sh_done) nxt = ST_GAP_POLL;
            ST_GAP_POLL: if (gap_end) nxt = (!wip || poll_hit) ? ST_FINISH : ST_RDSR;
            ST_FINISH:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            job_q       <= JOB_PROG;
            addr_q      <= '0;
            cnt_q       <= '0;
            lim_q       <= '0;
            polls       <= '0;
            idx         <= '0;
            gcnt        <= '0;
            launched    <= 1'b0;
            wip         <= 1'b0;
            err_len     <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            state   <= nxt;
            err_len <= (state == ST_IDLE) && start_prog && !len_ok;
            if (nxt != state) begin
                idx  <= '0;
                gcnt <= '0;
            end else begin
                if (sh_done) idx <= idx + CNT_W'(1);
                if (in_gap)  gcnt <= gcnt + GAP_W'(1);
            end
            launched <= (nxt != state || sh_done) ? 1'b0 : (launched || sh_go);
            if (accept) begin
                job_q       <= job_pick;
                addr_q      <= addr;
                cnt_q       <= byte_cnt;
                lim_q       <= poll_limit;
                polls       <= '0;
                err_timeout <= 1'b0;
            end
            if (state == ST_STATUS && sh_done) begin
                wip   <= sh_rx[0];
                polls <= polls + POLL_W'(1);
            end
            if (state == ST_GAP_POLL && gap_end && wip && poll_hit)
                err_timeout <= 1'b1;
        end
    end

    // outputs
    assign addr_sh = addr_q >> (8 * (ADDR_BYTES - 1 - int'(idx)));

    always_comb begin
        byte_st = 1'b0;
        sh_tx   = 8'h00;
        unique case (state)
            ST_WREN:   begin byte_st = 1'b1; sh_tx = OPC_WR_EN; end
            ST_OPCODE: begin
                byte_st = 1'b1;
                sh_tx   = (job_q == JOB_PROG) ? OPC_PAGE_WR :
                          (job_q == JOB_SEC)  ? OPC_SEC_ER  : OPC_CHIP_ER;
            end
            ST_ADDR:   begin byte_st = 1'b1; sh_tx = addr_sh[7:0]; end
            ST_DATA:   begin byte_st = 1'b1; sh_tx = data_in; end
            ST_RDSR:   begin byte_st = 1'b1; sh_tx = OPC_RD_STAT; end
            ST_STATUS: begin byte_st = 1'b1; sh_tx = 8'h00; end
            default:   begin byte_st = 1'b0; sh_tx = 8'h00; end
        endcase
        cs_n     = !byte_st;
        sh_go    = byte_st && !launched;
        data_req = sh_go && (state == ST_DATA);
        busy     = (state != ST_IDLE) && (state != ST_FINISH);
        done     = (state == ST_FINISH);
    end

    // R8: completion follows a busy interval
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R4: a rejected request leaves the link and busy untouched
    p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_len |-> (cs_n && !busy));

    // R2: data is only pulled inside a selected frame
    p_data_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> !cs_n);

    // R9: the timeout flag rises together with completion
    p_timeout_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> done);

endmodule

// File: rtl/spi_nor_writer.sv
module spi_nor_writer #(
    parameter int CLK_DIV    = 2,
    parameter int CS_GAP     = 2,
    parameter int POLL_W     = 16,
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_W     = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_prog,
    input  logic                            start_se,
    input  logic                            start_be,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [$clog2(PAGE_BYTES+1)-1:0] byte_cnt,
    input  logic [POLL_W-1:0]               poll_limit,
    input  logic [7:0]                      data_in,
    output logic                            data_req,
    output logic                            busy,
    output logic                            done,
    output logic                            err_len,
    output logic                            err_timeout,
    output logic                            spi_cs_n,
    output logic                            spi_sck,
    output logic                            spi_mosi,
    input  logic                            spi_miso
);
    logic       sh_go, sh_done;
    logic [7:0] sh_tx, sh_rx;

    flash_cmd_fsm #(
        .GAP(CS_GAP), .POLL_W(POLL_W), .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_prog(start_prog), .start_se(start_se), .start_be(start_be),
        .addr(addr), .byte_cnt(byte_cnt), .poll_limit(poll_limit),
        .data_in(data_in), .data_req(data_req),
        .busy(busy), .done(done), .err_len(err_len), .err_timeout(err_timeout),
        .cs_n(spi_cs_n), .sh_go(sh_go), .sh_tx(sh_tx),
        .sh_rx(sh_rx), .sh_done(sh_done)
    );

    spi_byte_shifter #(.DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_byte(sh_tx),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .rx_byte(sh_rx), .byte_done(sh_done)
    );

    // R3: the clock idles low whenever the device is deselected
    p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

endmodule

// File: tb/spi_nor_writer_bench.sv
module spi_nor_writer_bench;
    localparam int DIV = 1;
    localparam int GAP = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start_prog = 0, start_se = 0, start_be = 0;
    logic [23:0] addr = '0;
    logic [8:0]  byte_cnt = '0;
    logic [15:0] poll_limit = '0;
    logic [7:0]  data_in;
    logic        data_req, busy, done, err_len, err_timeout;
    logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    spi_nor_writer #(.CLK_DIV(DIV), .CS_GAP(GAP)) u_spi_nor_writer (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_se(start_se),
        .start_be(start_be), .addr(addr), .byte_cnt(byte_cnt),
        .poll_limit(poll_limit), .data_in(data_in), .data_req(data_req),
        .busy(busy), .done(done), .err_len(err_len), .err_timeout(err_timeout),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // data source: byte i of an operation is (i*37 + seed) mod 256
    int       dreq_total = 0, dbase = 0;
    int       seed = 0;
    always @(posedge clk) if (data_req) dreq_total <= dreq_total + 1;
    assign data_in = 8'((dreq_total - dbase) * 37 + seed);

    // flash link model: records bytes, frames and answers status reads
    logic [7:0] bytes_log [0:4095];
    int         byte_frame [0:4095];
    int         nbytes = 0, nframes = 0, frame_base = 0, bitc = 0;
    int         stat_total = 0, busy_until = 0;
    logic [7:0] sr = '0;
    logic [7:0] stat_byte;

    assign stat_byte = (stat_total < busy_until) ? 8'h03 : 8'h7C;
    assign spi_miso  = ((nbytes - frame_base) == 1 && bytes_log[frame_base] == 8'h05)
                       ? stat_byte[7 - bitc] : 1'b0;

    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (bitc == 7) begin
            bytes_log[nbytes]  = {sr[6:0], spi_mosi};
            byte_frame[nbytes] = nframes;
            nbytes = nbytes + 1;
            bitc   = 0;
        end else begin
            sr   = {sr[6:0], spi_mosi};
            bitc = bitc + 1;
        end
    end

    always @(posedge spi_cs_n) if (rst_n) begin
        if (nbytes > frame_base && bytes_log[frame_base] == 8'h05)
            stat_total = stat_total + 1;
        nframes    = nframes + 1;
        frame_base = nbytes;
    end

    // edge-rule and guard-interval monitors
    int   sck_idle_bad = 0, mosi_bad = 0, gap_min = 1000, gap_run = 0;
    logic p_sck = 0, p_mosi = 0;
    always @(negedge clk) if (rst_n) begin
        if (spi_cs_n && spi_sck) sck_idle_bad++;
        if (spi_sck && p_sck && spi_mosi != p_mosi) mosi_bad++;
        if (spi_cs_n) gap_run++;
        else begin
            if (gap_run > 0 && gap_run < gap_min) gap_min = gap_run;
            gap_run = 0;
        end
        p_sck  = spi_sck;
        p_mosi = spi_mosi;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [7:0] ex_b [0:4095];
    int         ex_f [0:4095];
    int         ex_n;

    task automatic push(input logic [7:0] b, input int f);
        ex_b[ex_n] = b;
        ex_f[ex_n] = f;
        ex_n++;
    endtask

    // reqs: bit2 program, bit1 sector, bit0 bulk; job: 0 prog, 1 sector, 2 bulk
    task automatic run_op(input logic [2:0] reqs, input int job, input logic [23:0] a,
                          input int cnt, input int wip_n, input int lim,
                          input bit poke, input string tag);
        int b0, f0, bad, nst, waited, busy_low;
        bit exp_to, seen;
        exp_to = (wip_n >= lim);
        nst    = exp_to ? lim : wip_n + 1;
        b0 = nbytes; f0 = nframes;
        dbase = dreq_total; seed = int'(a[7:0]) ^ cnt;
        busy_until = stat_total + wip_n;
        ex_n = 0;
        push(8'h06, 0);
        push(job == 0 ? 8'h02 : (job == 1 ? 8'hD8 : 8'hC7), 1);
        if (job != 2) begin
            push(a[23:16], 1); push(a[15:8], 1); push(a[7:0], 1);
        end
        if (job == 0) for (int i = 0; i < cnt; i++) push(8'((i * 37) + seed), 1);
        for (int p = 0; p < nst; p++) begin push(8'h05, 2 + p); push(8'h00, 2 + p); end

        @(negedge clk);
        addr = a; byte_cnt = 9'(cnt); poll_limit = 16'(lim);
        {start_prog, start_se, start_be} = reqs;
        @(negedge clk);
        {start_prog, start_se, start_be} = 3'b000;
        chk({"R8 busy after start ", tag}, int'(busy), 1);
        chk({"R9 timeout cleared at start ", tag}, int'(err_timeout), 0);
        waited = 0; busy_low = 0; seen = 0;
        while (!seen && waited < 20000) begin
            if (done) seen = 1;
            else begin
                if (!busy) busy_low++;
                if (poke && waited == 30) begin start_be = 1; start_se = 1; end
                if (poke && waited == 31) begin start_be = 0; start_se = 0; end
                @(negedge clk);
                waited++;
            end
        end
        chk({"R8 done seen ", tag}, int'(seen), 1);
        chk({"R8 busy low at done ", tag}, int'(busy), 0);
        chk({"R8 busy held until done ", tag}, busy_low, 0);
        chk({"R9 timeout flag at done ", tag}, int'(err_timeout), int'(exp_to));
        repeat (3) @(negedge clk);
        chk({"R9 timeout flag held ", tag}, int'(err_timeout), int'(exp_to));
        chk({"R2 R5 R6 byte count ", tag}, nbytes - b0, ex_n);
        chk({"R7 frame count ", tag}, nframes - f0, 2 + nst);
        if (job == 0) chk({"R2 data_req pulses ", tag}, dreq_total - dbase, cnt);
        bad = 0;
        for (int i = 0; i < ex_n && (b0 + i) < nbytes; i++) begin
            if (bytes_log[b0 + i] != ex_b[i] || byte_frame[b0 + i] - f0 != ex_f[i]) begin
                if (bad == 0)
                    $display("FAIL R2 R3 R5 R6 R7 %s: byte %0d actual %0h/frame %0d expected %0h/frame %0d",
                             tag, i, bytes_log[b0 + i], byte_frame[b0 + i] - f0, ex_b[i], ex_f[i]);
                bad++;
            end
        end
        n_chk++;
        if (bad != 0) n_bad++;
    endtask

    task automatic reject(input int cnt, input string tag);
        int f0; bit any_done;
        f0 = nframes; any_done = 0;
        @(negedge clk);
        byte_cnt = 9'(cnt); start_prog = 1; start_se = 1;
        @(negedge clk);
        start_prog = 0; start_se = 0;
        chk({"R4 err_len pulse ", tag}, int'(err_len), 1);
        chk({"R4 busy stays low ", tag}, int'(busy), 0);
        @(negedge clk);
        chk({"R4 err_len one cycle ", tag}, int'(err_len), 0);
        repeat (40) begin
            if (done || busy || !spi_cs_n) any_done = 1;
            @(negedge clk);
        end
        chk({"R4 no activity ", tag}, int'(any_done), 0);
        chk({"R4 no frames ", tag}, nframes - f0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #5;
        chk("R1 cs_n in reset", int'(spi_cs_n), 1);
        chk("R1 sck in reset", int'(spi_sck), 0);
        chk("R1 flags in reset", int'({busy, done, data_req, err_len, err_timeout}), 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", int'({busy, done, err_timeout, spi_cs_n}), 1);

        for (int c = 1; c <= 6; c++)
            run_op(3'b100, 0, 24'h123456 + 24'(c * 24'h010203), c, c % 4, 8, 0, "R2 sweep");
        run_op(3'b100, 0, 24'hFFFFFF, 255, 1, 4, 0, "R2 count 255");
        run_op(3'b100, 0, 24'h000100, 256, 2, 4, 1, "R2 R10 count 256 with busy poke");
        for (int s = 0; s < 3; s++)
            run_op(3'b010, 1, 24'hA50000 ^ 24'(s * 24'h3C0F1), 0, s, 5, 0, "R5 sector");
        run_op(3'b001, 2, 24'h0, 0, 0, 5, 0, "R6 bulk");
        run_op(3'b001, 2, 24'h0, 0, 5, 3, 0, "R9 bulk timeout");
        run_op(3'b010, 1, 24'h00FF00, 0, 3, 4, 0, "R9 limit just met");
        run_op(3'b010, 1, 24'h00FF00, 0, 4, 4, 0, "R9 limit exceeded");
        run_op(3'b111, 0, 24'h7E8123, 3, 0, 2, 0, "R10 priority prog");
        run_op(3'b011, 1, 24'h314159, 0, 0, 2, 0, "R10 priority sector");
        reject(0, "count 0");
        reject(257, "count 257");
        reject(511, "count 511");

        chk("R3 sck low while deselected", sck_idle_bad, 0);
        chk("R3 mosi stable while sck high", mosi_bad, 0);
        chk("R2 guard interval", int'(gap_min >= GAP), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule